// File: doc/BRIEF.md
# Pin Event Flag Detector

This block watches a bank of asynchronous input pins and records, per pin, whether a chosen condition has been seen. Every pin carries a 4-bit event code, written one pin at a time through a small configuration port. The code picks the condition (rising edge, falling edge, either edge, low level or high level) and the consequence. A set flag can drive the shared interrupt line, drive the shared DMA request line, or simply be recorded for software to poll.

Each pin passes through a synchronizer before edge detection. Edges come from comparing the current synchronized sample with the sample from the previous cycle. The flags appear together as one status vector in which bit N belongs to pin N. Software clears flags by writing ones to the matching bits. A DMA completion pulse clears the flags of pins whose code selects DMA.

Each pin runs a two-state machine. The states are `FLG_IDLE` (nothing recorded) and `FLG_SET` (flag held). The transitions are:
- Detect: `FLG_IDLE` to `FLG_SET` when the selected condition is seen.
- SoftClear: `FLG_SET` to `FLG_IDLE` on a write-one clear with no new event.
- DmaClear: `FLG_SET` to `FLG_IDLE` on a DMA completion pulse with no new event, for pins in DMA mode.
- Hold: stay in the current state in every other case.

Top module: `pin_evt_top`

## Requirements
- R1: While reset is low, and after it is released, `flags`, `irq` and `dma_req` are 0 and every pin's code is 0.
- R2: A pin change that is first sampled at clock edge E0 becomes visible in `flags` after edge E2 and not before. Bit N of `flags` belongs to pin N, so rising edges on pins 0 and 16 give 0x00010001.
- R3: The edge codes detect a change between two consecutive synchronized samples. Codes 1, 5 and 9 detect a rising edge. Codes 2, 6 and 10 detect a falling edge. Codes 3, 7 and 11 detect either edge.
- R4: Code 8 sets the flag while the synchronized pin is 0, and code 12 sets it while the pin is 1. While the level is still present, a write-one clear leaves the flag set.
- R5: Codes 0, 4, 13, 14 and 15 never set a flag.
- R6: `irq` is the OR of the flags of pins with codes 8 to 12. `dma_req` is the OR of the flags of pins with codes 1 to 3. Flags of pins with codes 5 to 7 drive neither output.
- R7: A cycle with `clr_we` high clears every flag whose `clr_mask` bit is 1. A 0 bit leaves its flag unchanged.
- R8: A one-cycle `dma_done` pulse clears the flags of pins with codes 1 to 3 and leaves all other flags unchanged.
- R9: If a pin detects an event in the same cycle as a clear (by write or by DMA), the flag is set after that edge.
- R10: When `cfg_we` is high, the code of pin `cfg_sel` becomes `cfg_code` at that edge. Changing a code never clears a flag that is already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 32 | Asynchronous pin levels |
| cfg_we | input | 1 | Event code write strobe |
| cfg_sel | input | 5 | Pin whose code is written |
| cfg_code | input | 4 | New event code |
| clr_we | input | 1 | Flag clear strobe |
| clr_mask | input | 32 | Write-one-to-clear mask |
| dma_done | input | 1 | DMA completion pulse |
| flags | output | 32 | Per-pin status flags |
| irq | output | 1 | Combined interrupt request |
| dma_req | output | 1 | Combined DMA request |

## Verification
The bench sweeps every code against both pin transitions. A design that swapped the edge senses, or that treated the reserved codes as active, would show the wrong flag or output line. It checks the exact cycle in which a flag appears, which catches a missing or extra synchronizer stage, and it issues a clear in the very cycle an event lands, where a clear-wins design would drop the event. It confirms that a held level survives a clear, that zero mask bits and DMA completion leave non-DMA flags untouched, and that rewriting a code keeps an existing flag. A design that got these wrong would lose events or re-arm its outputs wrongly.

// File: rtl/pin_evt_pkg.sv
package pin_evt_pkg;

    localparam int CODE_W = 4;

    typedef enum logic [CODE_W-1:0] {
        EC_OFF      = 4'd0,
        EC_DMA_RISE = 4'd1,
        EC_DMA_FALL = 4'd2,
        EC_DMA_BOTH = 4'd3,
        EC_FLG_RISE = 4'd5,
        EC_FLG_FALL = 4'd6,
        EC_FLG_BOTH = 4'd7,
        EC_IRQ_LOW  = 4'd8,
        EC_IRQ_RISE = 4'd9,
        EC_IRQ_FALL = 4'd10,
        EC_IRQ_BOTH = 4'd11,
        EC_IRQ_HIGH = 4'd12
    } evt_code_e;

    typedef enum logic {
        FLG_IDLE = 1'b0,
        FLG_SET  = 1'b1
    } flag_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic lvl_hi;
        logic lvl_lo;
        logic to_irq;
        logic to_dma;
    } sense_t;

    function automatic sense_t decode_code(input logic [CODE_W-1:0] code);
        sense_t s;
        s = '0;
        case (code)
            EC_DMA_RISE: begin s.rise = 1'b1; s.to_dma = 1'b1; end
            EC_DMA_FALL: begin s.fall = 1'b1; s.to_dma = 1'b1; end
            EC_DMA_BOTH: begin s.rise = 1'b1; s.fall = 1'b1; s.to_dma = 1'b1; end
            EC_FLG_RISE: s.rise = 1'b1;
            EC_FLG_FALL: s.fall = 1'b1;
            EC_FLG_BOTH: begin s.rise = 1'b1; s.fall = 1'b1; end
            EC_IRQ_LOW:  begin s.lvl_lo = 1'b1; s.to_irq = 1'b1; end
            EC_IRQ_RISE: begin s.rise = 1'b1; s.to_irq = 1'b1; end
            EC_IRQ_FALL: begin s.fall = 1'b1; s.to_irq = 1'b1; end
            EC_IRQ_BOTH: begin s.rise = 1'b1; s.fall = 1'b1; s.to_irq = 1'b1; end
            EC_IRQ_HIGH: begin s.lvl_hi = 1'b1; s.to_irq = 1'b1; end
            default:     s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= '0;
                    else        chain_q[g] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= '0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/pin_evt_cell.sv
module pin_evt_cell
    import pin_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_s,
    input  logic              code_we,
    input  logic [CODE_W-1:0] code_wdata,
    input  logic              sw_clr,
    input  logic              dma_done,
    output logic              flag,
    output logic              irq_src,
    output logic              dma_src
);

    logic [CODE_W-1:0] code_q;
    logic              prev_q;
    flag_state_e       state_q, state_d;
    sense_t            sense;
    logic              hit;
    logic              auto_clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            prev_q <= 1'b0;
        end else begin
            if (code_we) code_q <= code_wdata;
            prev_q <= pin_s;
        end
    end

    always_comb begin
        sense    = decode_code(code_q);
        hit      = (sense.rise   &  pin_s & ~prev_q)
                 | (sense.fall   & ~pin_s &  prev_q)
                 | (sense.lvl_hi &  pin_s)
                 | (sense.lvl_lo & ~pin_s);
        auto_clr = sense.to_dma & dma_done;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: if (hit) state_d = FLG_SET;
            FLG_SET:  if (!hit && (sw_clr || auto_clr)) state_d = FLG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        flag    = (state_q == FLG_SET);
        irq_src = flag & sense.to_irq;
        dma_src = flag & sense.to_dma;
    end

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag);

    // R7
    zero_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !sw_clr && !auto_clr) |=> flag);

    // R8
    dma_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && sense.to_dma && dma_done && !hit) |=> !flag);

    // R5
    quiet_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !code_we && (sense == '0)) |=> !flag);

    // R4
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sense.lvl_hi && pin_s) |=> flag);

endmodule

// File: rtl/pin_evt_top.sv
module pin_evt_top
    import pin_evt_pkg::*;
#(
    parameter int NUM_PINS    = 32,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                cfg_we,
    input  logic [SEL_W-1:0]    cfg_sel,
    input  logic [CODE_W-1:0]   cfg_code,
    input  logic                clr_we,
    input  logic [NUM_PINS-1:0] clr_mask,
    input  logic                dma_done,
    output logic [NUM_PINS-1:0] flags,
    output logic                irq,
    output logic                dma_req
);

    logic [NUM_PINS-1:0] pin_s;
    logic [NUM_PINS-1:0] irq_vec;
    logic [NUM_PINS-1:0] dma_vec;

    pin_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_s)
    );

    genvar p;
    generate
        for (p = 0; p < NUM_PINS; p++) begin : g_pin
            pin_evt_cell u_cell (
                .clk        (clk),
                .rst_n      (rst_n),
                .pin_s      (pin_s[p]),
                .code_we    (cfg_we && (cfg_sel == SEL_W'(p))),
                .code_wdata (cfg_code),
                .sw_clr     (clr_we && clr_mask[p]),
                .dma_done   (dma_done),
                .flag       (flags[p]),
                .irq_src    (irq_vec[p]),
                .dma_src    (dma_vec[p])
            );
        end
    endgenerate

    assign irq     = |irq_vec;
    assign dma_req = |dma_vec;

    // R6
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags != '0));

    // R6
    dma_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (flags != '0));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |-> (flags == '0 && !irq && !dma_req));

endmodule

// File: tb/tb_pin_evt_top.sv
module tb_pin_evt_top;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 21;

    // {code[3:0], start level, end level, flag, irq, dma}
    localparam logic [8:0] VEC [NV] = '{
        {4'd0,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {4'd1,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
        {4'd1,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {4'd2,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
        {4'd2,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {4'd3,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
        {4'd3,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
        {4'd5,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        {4'd6,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        {4'd6,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {4'd7,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        {4'd8,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
        {4'd8,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        {4'd9,  1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        {4'd9,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {4'd10, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
        {4'd11, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        {4'd12, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        {4'd12, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {4'd4,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {4'd14, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin_in = '0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_sel = '0;
    logic [3:0]  cfg_code = '0;
    logic        clr_we = 1'b0;
    logic [31:0] clr_mask = '0;
    logic        dma_done = 1'b0;
    logic [31:0] flags;
    logic        irq;
    logic        dma_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pin_evt_top dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_code (cfg_code),
        .clr_we   (clr_we),
        .clr_mask (clr_mask),
        .dma_done (dma_done),
        .flags    (flags),
        .irq      (irq),
        .dma_req  (dma_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        pin_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic set_code(input int pin, input logic [3:0] code);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_sel = 5'(pin);
        cfg_code = code;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clear(input logic [31:0] m);
        @(negedge clk);
        clr_we = 1'b1;
        clr_mask = m;
        @(negedge clk);
        clr_we = 1'b0;
        clr_mask = '0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        // R1: outputs held low during reset
        check("R1 flags in reset", flags, 32'h0);
        check("R1 irq in reset", {31'b0, irq}, 32'h0);
        do_reset();
        check("R1 flags after reset", flags, 32'h0);
        check("R1 dma_req after reset", {31'b0, dma_req}, 32'h0);
        // R1: reset codes are 0, so an edge sets nothing
        pin_in[9] = 1'b1;
        settle();
        check("R1 code zero after reset", flags, 32'h0);

        // Table sweep on pin 0: R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            set_code(0, 4'd0);
            clear(32'hFFFF_FFFF);
            pin_in[0] = VEC[i][4];
            settle();
            set_code(0, VEC[i][8:5]);
            clear(32'hFFFF_FFFF);
            @(negedge clk);
            pin_in[0] = VEC[i][3];
            settle();
            check($sformatf("R3/R4/R5 flag code %0d vec %0d", VEC[i][8:5], i), flags, {31'b0, VEC[i][2]});
            check($sformatf("R6 irq code %0d vec %0d", VEC[i][8:5], i), {31'b0, irq}, {31'b0, VEC[i][1]});
            check($sformatf("R6 dma_req code %0d vec %0d", VEC[i][8:5], i), {31'b0, dma_req}, {31'b0, VEC[i][0]});
        end

        // R2: latency and bit mapping
        do_reset();
        set_code(0, 4'd9);
        set_code(16, 4'd9);
        pin_in[0] = 1'b1;
        pin_in[16] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R2 not visible after E0", flags, 32'h0);
        @(negedge clk);
        check("R2 not visible after E1", flags, 32'h0);
        @(negedge clk);
        check("R2 pins 0 and 16", flags, 32'h0001_0001);

        // R10: code change keeps flag; irq follows code
        set_code(0, 4'd0);
        check("R10 flag kept after code change", flags, 32'h0001_0001);
        check("R10 irq from pin 16", {31'b0, irq}, 32'h1);
        set_code(16, 4'd0);
        check("R10 both flags kept", flags, 32'h0001_0001);
        check("R10 irq off with codes 0", {31'b0, irq}, 32'h0);

        // R7: zero mask bits ignored, one bits clear
        do_reset();
        set_code(4, 4'd9);
        pin_in[4] = 1'b1;
        settle();
        clear(~32'h0000_0010);
        check("R7 zero bit has no effect", flags, 32'h0000_0010);
        clear(32'h0000_0010);
        check("R7 one bit clears", flags, 32'h0);

        // R4: level re-asserts through clear
        do_reset();
        set_code(2, 4'd12);
        pin_in[2] = 1'b1;
        settle();
        clear(32'h0000_0004);
        check("R4 level flag survives clear", flags, 32'h0000_0004);
        check("R4 irq held", {31'b0, irq}, 32'h1);
        pin_in[2] = 1'b0;
        settle();
        clear(32'h0000_0004);
        check("R4 clears once level gone", flags, 32'h0);

        // R8: dma_done clears only DMA-mode flags
        do_reset();
        set_code(3, 4'd1);
        set_code(5, 4'd9);
        pin_in[3] = 1'b1;
        pin_in[5] = 1'b1;
        settle();
        check("R8 both flagged", flags, 32'h0000_0028);
        check("R8 dma_req raised", {31'b0, dma_req}, 32'h1);
        @(negedge clk);
        dma_done = 1'b1;
        @(negedge clk);
        dma_done = 1'b0;
        check("R8 dma flag cleared only", flags, 32'h0000_0020);
        check("R8 dma_req dropped", {31'b0, dma_req}, 32'h0);

        // R9: set wins over clear in the same cycle
        do_reset();
        pin_in[7] = 1'b1;
        settle();
        set_code(7, 4'd10);
        pin_in[7] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R9 no flag before E2", flags, 32'h0);
        clr_we = 1'b1;
        clr_mask = 32'h0000_0080;
        @(negedge clk);
        clr_we = 1'b0;
        clr_mask = '0;
        check("R9 set wins over clear", flags, 32'h0000_0080);
        clear(32'h0000_0080);
        check("R9 later clear works", flags, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule